// File: doc/BRIEF.md
# Superframe-Aligned Robbed-Bit Signaling Buffer

This block keeps the per-channel robbed-bit signaling state of a T1 framer for both traffic directions. On the receive side, a strobe delivers the four signaling bits (A, B, C, D) just extracted for one channel. The block presents the held values through a random-read channel port and through a one-bit serial signaling output that is addressed by channel and bit position. On the transmit side, a host writes new signaling values per channel, and the insertion logic reads the value to launch through its own channel-indexed port.

A single mode bit, held in a small read/write register, sets the update policy for both directions at once. In immediate mode, every new value becomes visible one clock after it arrives. In superframe mode, new values collect in a shadow bank. The whole shadow bank moves into the visible (active) bank in one clock when the superframe boundary pulse arrives, so a channel never shows a mix of old and new bits. Extracting bits from the line and inserting them into the line are done elsewhere.

Top module: `rbs_update_buffer`

## Requirements
- R1: The mode bit is written by `cfg_wr` with `cfg_wdata` and read back on `cfg_defer_q` one clock later. It resets to 0, which selects immediate mode, and all signaling values reset to 0.
- R2: One write of the mode bit switches the receive and transmit directions together.
- R3: In immediate mode, a receive strobe for channel c makes `rd_bits` show the new value for c one clock after the capturing edge, and other channels keep their values.
- R4: In superframe mode, received values stay invisible on `rd_bits` and `ser_bit` until a `sf_boundary` pulse. One clock after that pulse, every pending channel shows its new value together.
- R5: In immediate mode, a host write for channel c appears on `ins_bits` one clock after the capturing edge.
- R6: In superframe mode, host writes stay off `ins_bits` until the next `sf_boundary` pulse and appear one clock after it.
- R7: A strobe or host write in the same cycle as a boundary pulse goes to the shadow bank only. It is committed at the following boundary.
- R8: A mode change acts from the next clock. A strobe in the same cycle as the mode write follows the old mode.
- R9: While immediate mode is selected, the shadow bank follows the active bank, so pending superframe-mode values are dropped when the mode is switched to immediate. A later boundary in superframe mode without new input changes nothing.
- R10: `ser_bit` gives one bit of the active receive value of channel `ser_chan`. Bits are packed with A at bit 3, B at 2, C at 1 and D at 0, and `ser_sel` value 0, 1, 2, 3 picks A, B, C, D.
- R11: Strobes and writes with a channel number of 24 or more are ignored, and reads of such channels return 0.
- R12: A boundary pulse in immediate mode has no effect on any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the mode bit |
| cfg_wdata | input | 1 | Mode value: 1 superframe, 0 immediate |
| cfg_defer_q | output | 1 | Current mode bit |
| sf_boundary | input | 1 | Superframe boundary pulse |
| rx_strobe | input | 1 | New receive signaling value valid |
| rx_chan | input | 5 | Channel of the receive value |
| rx_bits | input | 4 | Receive signaling bits A..D |
| rd_chan | input | 5 | Channel read on rd_bits |
| rd_bits | output | 4 | Active receive value of rd_chan |
| ser_chan | input | 5 | Channel for the serial output |
| ser_sel | input | 2 | Bit position for the serial output |
| ser_bit | output | 1 | Serial receive signaling bit |
| tx_wr | input | 1 | Host transmit write strobe |
| tx_chan | input | 5 | Channel of the host write |
| tx_bits | input | 4 | Transmit signaling bits A..D |
| ins_chan | input | 5 | Channel read by the insertion logic |
| ins_bits | output | 4 | Active transmit value of ins_chan |

## Verification
Each strobe, write, mode write or boundary pulse is captured on one rising edge. Its effect is due on the outputs right after that edge, because the read paths are combinational from the active banks. The bench drives inputs at the falling edge and lets exactly one rising edge pass. It then sets the read selectors and samples at the next falling edge. For the deferred and same-cycle cases, it samples both before and after the boundary to show the one-boundary delay.

// File: rtl/rbs_pkg.sv
// Shared definitions for the robbed-bit signaling update buffer.
// Assumes nothing beyond the default sizes listed here.
package rbs_pkg;
    localparam int DEF_NUM_CH = 24;
    localparam int DEF_SIG_W  = 4;

    typedef enum logic {
        UPD_IMMEDIATE  = 1'b0,
        UPD_SUPERFRAME = 1'b1
    } upd_mode_e;
endpackage

// File: rtl/rbs_mode_reg.sv
// Holds the update-mode bit shared by both directions.
// Assumes cfg_wr is a single-cycle write strobe; the value resets to immediate.
module rbs_mode_reg
    import rbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic      wdata,
    output upd_mode_e mode_q
);
    // Capture a new mode on a write; reset to immediate update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= UPD_IMMEDIATE;
        end else if (wr) begin
            mode_q <= wdata ? UPD_SUPERFRAME : UPD_IMMEDIATE;
        end
    end
endmodule

// File: rtl/rbs_chan_mux.sv
// Selects one channel field out of a flattened channel bank.
// Assumes channel i sits at bits [i*W +: W]; out-of-range selects give zero.
module rbs_chan_mux #(
    parameter  int N  = 24,
    parameter  int W  = 4,
    localparam int CW = $clog2(N)
) (
    input  logic [N*W-1:0] flat,
    input  logic [CW-1:0]  sel,
    output logic [W-1:0]   q
);
    // Compare the select against every channel index and pick the match.
    always_comb begin
        q = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == CW'(i)) begin
                q = flat[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/rbs_dbl_bank.sv
// Shadow/active register pair per channel for one direction.
// Immediate mode: writes land in both banks, and the shadow follows the active bank.
// Deferred mode: writes land in the shadow only, and a commit pulse copies all
// shadows into the active bank in one clock.
// Assumes wr_chan values at or beyond N are to be ignored.
module rbs_dbl_bank #(
    parameter  int N  = 24,
    parameter  int W  = 4,
    localparam int CW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           defer,
    input  logic           commit,
    input  logic           wr_en,
    input  logic [CW-1:0]  wr_chan,
    input  logic [W-1:0]   wr_bits,
    output logic [N*W-1:0] active_flat,
    output logic [N*W-1:0] shadow_flat
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic         hit;
        logic [W-1:0] sh_q;
        logic [W-1:0] ac_q;

        assign hit = wr_en && (wr_chan == CW'(g));

        // Update this channel's shadow and active value per the current mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '0;
                ac_q <= '0;
            end else if (defer) begin
                if (hit) begin
                    sh_q <= wr_bits;
                end
                if (commit) begin
                    ac_q <= sh_q;
                end
            end else if (hit) begin
                sh_q <= wr_bits;
                ac_q <= wr_bits;
            end else begin
                sh_q <= ac_q;
            end
        end

        assign active_flat[g*W +: W] = ac_q;
        assign shadow_flat[g*W +: W] = sh_q;
    end
endmodule

// File: rtl/rbs_update_buffer.sv
// Top of the robbed-bit signaling update buffer: one mode register, one
// double bank for receive and one for transmit, and the read ports.
// Assumes SIG_W >= 2 and that sf_boundary is a one-cycle pulse.
module rbs_update_buffer
    import rbs_pkg::*;
#(
    parameter  int NUM_CH = DEF_NUM_CH,
    parameter  int SIG_W  = DEF_SIG_W,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int SEL_W  = $clog2(SIG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_wdata,
    output logic             cfg_defer_q,
    input  logic             sf_boundary,
    input  logic             rx_strobe,
    input  logic [CH_W-1:0]  rx_chan,
    input  logic [SIG_W-1:0] rx_bits,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [SIG_W-1:0] rd_bits,
    input  logic [CH_W-1:0]  ser_chan,
    input  logic [SEL_W-1:0] ser_sel,
    output logic             ser_bit,
    input  logic             tx_wr,
    input  logic [CH_W-1:0]  tx_chan,
    input  logic [SIG_W-1:0] tx_bits,
    input  logic [CH_W-1:0]  ins_chan,
    output logic [SIG_W-1:0] ins_bits
);
    upd_mode_e               mode_q;
    logic                    defer_q;
    logic [NUM_CH*SIG_W-1:0] rx_act_flat;
    logic [NUM_CH*SIG_W-1:0] rx_sh_flat;
    logic [NUM_CH*SIG_W-1:0] tx_act_flat;
    logic [NUM_CH*SIG_W-1:0] tx_sh_flat;
    logic [SIG_W-1:0]        ser_word;

    rbs_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .mode_q (mode_q)
    );

    assign defer_q     = (mode_q == UPD_SUPERFRAME);
    assign cfg_defer_q = defer_q;

    rbs_dbl_bank #(.N(NUM_CH), .W(SIG_W)) u_rx_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .defer       (defer_q),
        .commit      (sf_boundary),
        .wr_en       (rx_strobe),
        .wr_chan     (rx_chan),
        .wr_bits     (rx_bits),
        .active_flat (rx_act_flat),
        .shadow_flat (rx_sh_flat)
    );

    rbs_dbl_bank #(.N(NUM_CH), .W(SIG_W)) u_tx_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .defer       (defer_q),
        .commit      (sf_boundary),
        .wr_en       (tx_wr),
        .wr_chan     (tx_chan),
        .wr_bits     (tx_bits),
        .active_flat (tx_act_flat),
        .shadow_flat (tx_sh_flat)
    );

    rbs_chan_mux #(.N(NUM_CH), .W(SIG_W)) u_rd_mux (
        .flat (rx_act_flat),
        .sel  (rd_chan),
        .q    (rd_bits)
    );

    rbs_chan_mux #(.N(NUM_CH), .W(SIG_W)) u_ser_mux (
        .flat (rx_act_flat),
        .sel  (ser_chan),
        .q    (ser_word)
    );

    rbs_chan_mux #(.N(NUM_CH), .W(SIG_W)) u_ins_mux (
        .flat (tx_act_flat),
        .sel  (ins_chan),
        .q    (ins_bits)
    );

    // Serial bit: selector 0 takes the most significant (A) bit.
    always_comb begin
        ser_bit = 1'b0;
        for (int k = 0; k < SIG_W; k++) begin
            if (ser_sel == SEL_W'(k)) begin
                ser_bit = ser_word[SIG_W-1-k];
            end
        end
    end
endmodule

// File: rtl/rbs_update_buffer_chk.sv
// Assertion checker for rbs_update_buffer, attached by bind below.
// Assumes it sees the top's mode and both banks' active and shadow vectors.
module rbs_update_buffer_chk #(
    parameter  int N  = 24,
    parameter  int W  = 4,
    localparam int CW = $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_wr,
    input logic           cfg_wdata,
    input logic           defer,
    input logic           sf_boundary,
    input logic           rx_strobe,
    input logic [CW-1:0]  rx_chan,
    input logic [W-1:0]   rx_bits,
    input logic           tx_wr,
    input logic [CW-1:0]  tx_chan,
    input logic [W-1:0]   tx_bits,
    input logic [N*W-1:0] rx_act,
    input logic [N*W-1:0] rx_sh,
    input logic [N*W-1:0] tx_act,
    input logic [N*W-1:0] tx_sh
);
    localparam logic [CW:0] NLIM = (CW+1)'(N);

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (defer == $past(cfg_wdata))); // R1
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(defer)); // R8
    AST_RX_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (defer && !sf_boundary) |=> $stable(rx_act)); // R4
    AST_TX_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (defer && !sf_boundary) |=> $stable(tx_act)); // R6
    AST_RX_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (defer && sf_boundary) |=> (rx_act == $past(rx_sh))); // R7
    AST_TX_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (defer && sf_boundary) |=> (tx_act == $past(tx_sh))); // R7
    AST_RX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !defer |=> (rx_sh == rx_act)); // R9
    AST_TX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !defer |=> (tx_sh == tx_act)); // R9
    AST_RX_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!defer && !rx_strobe) |=> $stable(rx_act)); // R12
    AST_RX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!defer && rx_strobe && ({1'b0, rx_chan} >= NLIM)) |=> $stable(rx_act)); // R11
    AST_TX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!defer && tx_wr && ({1'b0, tx_chan} >= NLIM)) |=> $stable(tx_act)); // R11

    for (genvar g = 0; g < N; g++) begin : g_imm
        AST_RX_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
            (!defer && rx_strobe && (rx_chan == CW'(g))) |=> (rx_act[g*W +: W] == $past(rx_bits))); // R3
        AST_TX_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
            (!defer && tx_wr && (tx_chan == CW'(g))) |=> (tx_act[g*W +: W] == $past(tx_bits))); // R5
    end
endmodule

bind rbs_update_buffer rbs_update_buffer_chk #(.N(NUM_CH), .W(SIG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .defer       (defer_q),
    .sf_boundary (sf_boundary),
    .rx_strobe   (rx_strobe),
    .rx_chan     (rx_chan),
    .rx_bits     (rx_bits),
    .tx_wr       (tx_wr),
    .tx_chan     (tx_chan),
    .tx_bits     (tx_bits),
    .rx_act      (rx_act_flat),
    .rx_sh       (rx_sh_flat),
    .tx_act      (tx_act_flat),
    .tx_sh       (tx_sh_flat)
);

// File: tb/test_rbs_update_buffer.sv
// Directed bench for rbs_update_buffer: one task per scenario.
module test_rbs_update_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_wdata = 1'b0, cfg_defer_q;
    logic       sf_boundary = 1'b0;
    logic       rx_strobe = 1'b0;
    logic [4:0] rx_chan = '0, rd_chan = '0, ser_chan = '0, tx_chan = '0, ins_chan = '0;
    logic [3:0] rx_bits = '0, rd_bits, tx_bits = '0, ins_bits;
    logic [1:0] ser_sel = '0;
    logic       ser_bit;
    logic       tx_wr = 1'b0;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    rbs_update_buffer i_rbs_update_buffer (
        .clk, .rst_n, .cfg_wr, .cfg_wdata, .cfg_defer_q, .sf_boundary,
        .rx_strobe, .rx_chan, .rx_bits, .rd_chan, .rd_bits,
        .ser_chan, .ser_sel, .ser_bit, .tx_wr, .tx_chan, .tx_bits,
        .ins_chan, .ins_bits
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One rising edge, then back to the falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rx_put(input logic [4:0] ch, input logic [3:0] b);
        rx_strobe = 1'b1; rx_chan = ch; rx_bits = b;
        cyc();
        rx_strobe = 1'b0;
    endtask

    task automatic tx_put(input logic [4:0] ch, input logic [3:0] b);
        tx_wr = 1'b1; tx_chan = ch; tx_bits = b;
        cyc();
        tx_wr = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        cfg_wr = 1'b1; cfg_wdata = m;
        cyc();
        cfg_wr = 1'b0;
    endtask

    task automatic pulse();
        sf_boundary = 1'b1;
        cyc();
        sf_boundary = 1'b0;
    endtask

    task automatic rd(input logic [4:0] ch, output logic [3:0] v);
        rd_chan = ch; #1; v = rd_bits;
    endtask

    task automatic ins(input logic [4:0] ch, output logic [3:0] v);
        ins_chan = ch; #1; v = ins_bits;
    endtask

    task automatic ser(input logic [4:0] ch, input logic [1:0] s, output logic [3:0] v);
        ser_chan = ch; ser_sel = s; #1; v = {3'b000, ser_bit};
    endtask

    task automatic t_reset();
        logic [3:0] v;
        check("R1 mode after reset", {3'b000, cfg_defer_q}, 4'h0);
        rd(5'd0, v);  check("R1 rx ch0 after reset", v, 4'h0);
        rd(5'd23, v); check("R1 rx ch23 after reset", v, 4'h0);
        ins(5'd7, v); check("R1 tx ch7 after reset", v, 4'h0);
    endtask

    task automatic t_immediate_rx();
        logic [3:0] v;
        rx_put(5'd5, 4'hA);
        rd(5'd5, v);  check("R3 rx ch5 immediate", v, 4'hA);
        rx_put(5'd23, 4'h3);
        rd(5'd23, v); check("R3 rx ch23 immediate", v, 4'h3);
        rd(5'd5, v);  check("R3 rx ch5 untouched", v, 4'hA);
    endtask

    task automatic t_serial();
        logic [3:0] v;
        ser(5'd5, 2'd0, v); check("R10 serial A", v, 4'h1);
        ser(5'd5, 2'd1, v); check("R10 serial B", v, 4'h0);
        ser(5'd5, 2'd2, v); check("R10 serial C", v, 4'h1);
        ser(5'd5, 2'd3, v); check("R10 serial D", v, 4'h0);
    endtask

    task automatic t_immediate_tx();
        logic [3:0] v;
        tx_put(5'd7, 4'h6);
        ins(5'd7, v); check("R5 tx ch7 immediate", v, 4'h6);
    endtask

    task automatic t_boundary_ignored();
        logic [3:0] v;
        pulse();
        rd(5'd5, v);  check("R12 rx after boundary in immediate", v, 4'hA);
        ins(5'd7, v); check("R12 tx after boundary in immediate", v, 4'h6);
    endtask

    task automatic t_mode_switch();
        logic [3:0] v;
        cfg_wr = 1'b1; cfg_wdata = 1'b1;
        rx_strobe = 1'b1; rx_chan = 5'd5; rx_bits = 4'h5;
        cyc();
        cfg_wr = 1'b0; rx_strobe = 1'b0;
        rd(5'd5, v); check("R8 strobe with mode write uses old mode", v, 4'h5);
        check("R1 mode readback", {3'b000, cfg_defer_q}, 4'h1);
    endtask

    task automatic t_deferred_rx();
        logic [3:0] v;
        rx_put(5'd5, 4'hC);
        rx_put(5'd6, 4'h9);
        rd(5'd5, v); check("R4 rx ch5 held before boundary", v, 4'h5);
        rd(5'd6, v); check("R4 rx ch6 held before boundary", v, 4'h0);
        ser(5'd5, 2'd0, v); check("R4 serial held before boundary", v, 4'h0);
        pulse();
        rd(5'd5, v); check("R4 rx ch5 after boundary", v, 4'hC);
        rd(5'd6, v); check("R4 rx ch6 after boundary", v, 4'h9);
        ser(5'd5, 2'd0, v); check("R4 serial after boundary", v, 4'h1);
    endtask

    task automatic t_deferred_tx();
        logic [3:0] v;
        tx_put(5'd7, 4'hE);
        ins(5'd7, v); check("R6 R2 tx held before boundary", v, 4'h6);
        cyc();
        ins(5'd7, v); check("R6 tx still held", v, 4'h6);
        pulse();
        ins(5'd7, v); check("R6 tx after boundary", v, 4'hE);
    endtask

    task automatic t_collision();
        logic [3:0] v;
        sf_boundary = 1'b1;
        tx_wr = 1'b1; tx_chan = 5'd7; tx_bits = 4'h1;
        rx_strobe = 1'b1; rx_chan = 5'd6; rx_bits = 4'h2;
        cyc();
        sf_boundary = 1'b0; tx_wr = 1'b0; rx_strobe = 1'b0;
        ins(5'd7, v); check("R7 tx write at boundary not committed", v, 4'hE);
        rd(5'd6, v);  check("R7 rx strobe at boundary not committed", v, 4'h9);
        cyc();
        pulse();
        ins(5'd7, v); check("R7 tx committed at next boundary", v, 4'h1);
        rd(5'd6, v);  check("R7 rx committed at next boundary", v, 4'h2);
    endtask

    task automatic t_out_of_range();
        logic [3:0] v;
        rx_put(5'd24, 4'hF);
        rx_put(5'd31, 4'hF);
        tx_put(5'd30, 4'hF);
        pulse();
        rd(5'd0, v);  check("R11 rx ch0 untouched", v, 4'h0);
        rd(5'd23, v); check("R11 rx ch23 untouched", v, 4'h3);
        rd(5'd24, v); check("R11 rx read ch24 zero", v, 4'h0);
        ins(5'd0, v); check("R11 tx ch0 untouched", v, 4'h0);
        ins(5'd7, v); check("R11 tx ch7 untouched", v, 4'h1);
    endtask

    task automatic t_tracking();
        logic [3:0] v;
        rx_put(5'd5, 4'h7);
        tx_put(5'd7, 4'h8);
        set_mode(1'b0);
        check("R2 mode cleared", {3'b000, cfg_defer_q}, 4'h0);
        cyc();
        rd(5'd5, v);  check("R9 rx pending dropped", v, 4'hC);
        ins(5'd7, v); check("R9 tx pending dropped", v, 4'h1);
        set_mode(1'b1);
        pulse();
        rd(5'd5, v);  check("R9 rx unchanged by empty boundary", v, 4'hC);
        ins(5'd7, v); check("R9 tx unchanged by empty boundary", v, 4'h1);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_immediate_rx();
        t_serial();
        t_immediate_tx();
        t_boundary_ignored();
        t_mode_switch();
        t_deferred_rx();
        t_deferred_tx();
        t_collision();
        t_out_of_range();
        t_tracking();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule